// File: doc/BRIEF.md
# Programmable Clock Divider with Staged Update and Lock Status

The block derives a slower clock from a reference clock by integer division. A single 32-bit configuration word sets the number of reference cycles the output spends high and low, an edge-select bit for odd ratios, a bypass bit and a no-update bit. The word is first captured in a shadow copy. The running (active) setting is replaced only after a write whose no-update bit is clear, and only at the end of an output period. The division ratio is the high count plus the low count.

Software programs a ratio N as follows. For even N it writes high = low = N/2 with edge-select clear. For odd N it writes low = N/2 + 1 and high = N/2 (integer division) with edge-select set. For N = 1 it sets bypass. The extra half cycle for odd ratios comes from a register clocked on the falling reference edge, so the duty cycle stays at 50%. A lock flag drops on the cycle after a committing write and returns once the new setting has run for a fixed settle time. Software polls this flag to learn that a change has finished.

Top module: `clkdiv_prog`

## Requirements
- R1: After synchronous reset the divider is in bypass: `clk_div_o` follows `clk_ref` and `lock_o` is 1.
- R2: Configuration word fields are: low count in bits [5:0], high count in bits [11:6], edge-select in bit 12, bypass in bit 13, and no-update in bit 14. Bits [31:15] are ignored. With edge-select 0 and bypass 0, the output is high for `high` reference cycles and then low for `low` cycles, giving a period of high+low.
- R3: While the active bypass bit is 1, `clk_div_o` equals `clk_ref` and the counts have no effect.
- R4: With edge-select 1, the high phase is lengthened and the low phase shortened by half a reference cycle, using the falling edge. An odd ratio encoded as low = high + 1 therefore gives a 50% duty cycle.
- R5: A write with the no-update bit set only changes the shadow copy. The output keeps its current setting and `lock_o` stays as it was.
- R6: A write with the no-update bit clear captures its word and requests a commit. `lock_o` is 0 in the cycle after the write edge.
- R7: A pending setting is applied only after the last low cycle of a period, or at any cycle while in bypass. The output is held low for one extra reference cycle while the setting is loaded. The next period begins with its high phase.
- R8: `lock_o` rises exactly SETTLE_CYCLES reference cycles after the new setting is loaded, provided no further commit is pending. It therefore stays low for more than SETTLE_CYCLES cycles.
- R9: With bypass clear, a low or high count of zero acts as a count of 1.
- R10: A commit written while an earlier one is pending or settling keeps `lock_o` low. The shadow contents at load time are the setting applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wdata | input | 32 | Configuration word |
| clk_div_o | output | 1 | Divided (or bypassed) clock |
| lock_o | output | 1 | Lock status, 1 when the active setting has settled |

## Verification
On every cycle, the embedded assertions check the following:
- the lock flag falls after each commit and never falls otherwise;
- a rising lock is preceded by at least SETTLE_CYCLES low cycles;
- every high phase starts with the full high count;
- a swap never cuts a high phase short;
- bypass leaves the counter idle;
- the active counts are never zero.

The exact output waveform can only be shown by the bench's scenarios, which compare it against a period-position reference model at both reference edges. This covers the half-cycle stretch for odd ratios, the extra low cycle at a swap, staged words that leave the output untouched, ignored upper bits, zero counts, back-to-back commits and the maximum 63+63 ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int WORD_W    = 32;
  localparam int CNT_W     = 6;
  localparam int LO_LSB    = 0;
  localparam int HI_LSB    = LO_LSB + CNT_W;
  localparam int EDGE_BIT  = HI_LSB + CNT_W;
  localparam int BYP_BIT   = EDGE_BIT + 1;
  localparam int NOUPD_BIT = BYP_BIT + 1;

  typedef struct packed {
    logic             byp;
    logic             edge_sel;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } div_set_t;

  function automatic div_set_t unpack_word(input logic [WORD_W-1:0] w);
    div_set_t s;
    s.lo       = w[LO_LSB +: CNT_W];
    s.hi       = w[HI_LSB +: CNT_W];
    s.edge_sel = w[EDGE_BIT];
    s.byp      = w[BYP_BIT];
    return s;
  endfunction

  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction
endpackage

// File: rtl/clkdiv_cfg_regs.sv
module clkdiv_cfg_regs
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              take,
  output div_set_t          shadow,
  output logic              pend,
  output logic              commit_wr
);
  logic unused_upper;
  assign unused_upper = ^wdata[WORD_W-1:NOUPD_BIT+1];

  assign commit_wr = we & ~wdata[NOUPD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '{byp: 1'b1, edge_sel: 1'b0, hi: CNT_W'(1), lo: CNT_W'(1)};
      pend   <= 1'b0;
    end else begin
      if (we) shadow <= unpack_word(wdata);
      if (commit_wr)  pend <= 1'b1;
      else if (take)  pend <= 1'b0;
    end
  end

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[NOUPD_BIT] && !pend) |=> !pend) else $error("staged write raised commit"); // R5
endmodule

// File: rtl/clkdiv_phase_gen.sv
module clkdiv_phase_gen
  import clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pend,
  input  div_set_t shadow,
  output logic     take,
  output logic     load,
  output logic     phase_hi,
  output logic     act_byp,
  output logic     act_edge
);
  logic [CNT_W-1:0] act_lo, act_hi, cnt;
  logic             swap_q;
  logic             boundary;

  assign boundary = act_byp || (!phase_hi && cnt == '0);
  assign take     = !swap_q && boundary && pend;
  assign load     = swap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_lo   <= CNT_W'(1);
      act_hi   <= CNT_W'(1);
      act_byp  <= 1'b1;
      act_edge <= 1'b0;
      cnt      <= '0;
      phase_hi <= 1'b0;
      swap_q   <= 1'b0;
    end else if (swap_q) begin
      swap_q   <= 1'b0;
      act_lo   <= eff_count(shadow.lo);
      act_hi   <= eff_count(shadow.hi);
      act_byp  <= shadow.byp;
      act_edge <= shadow.edge_sel;
      phase_hi <= !shadow.byp;
      cnt      <= eff_count(shadow.hi) - 1'b1;
    end else if (take) begin
      swap_q   <= 1'b1;
      phase_hi <= 1'b0;
    end else if (!act_byp) begin
      if (cnt == '0) begin
        phase_hi <= !phase_hi;
        cnt      <= phase_hi ? act_lo - 1'b1 : act_hi - 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_HIGH_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_hi) |-> (cnt == act_hi - 1'b1)) else $error("short high phase"); // R2
  AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
    $fell(phase_hi) |-> !swap_q) else $error("swap cut high phase"); // R7
  AST_BYP_IDLE: assert property (@(posedge clk) disable iff (rst)
    act_byp |-> !phase_hi) else $error("counter active in bypass"); // R3
  AST_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (act_lo != '0) && (act_hi != '0)) else $error("zero active count"); // R9
endmodule

// File: rtl/clkdiv_lock_ctrl.sv
module clkdiv_lock_ctrl #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic commit_wr,
  input  logic load,
  input  logic pend,
  output logic lock
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  logic [SW-1:0] scnt;
  logic          run;
  logic [SW-1:0] low_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      scnt <= '0;
      run  <= 1'b0;
      lock <= 1'b1;
    end else begin
      if (load) begin
        scnt <= SW'(SETTLE_CYCLES - 1);
        run  <= 1'b1;
      end else if (run && scnt != '0) begin
        scnt <= scnt - 1'b1;
      end
      if (commit_wr) begin
        lock <= 1'b0;
      end else if (run && scnt == '0 && !pend && !load) begin
        lock <= 1'b1;
        run  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               low_len <= '0;
    else if (lock)                         low_len <= '0;
    else if (low_len != SW'(SETTLE_CYCLES)) low_len <= low_len + 1'b1;
  end

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
    commit_wr |=> !lock) else $error("lock kept after commit"); // R6
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lock && !commit_wr) |=> lock) else $error("lock fell without commit"); // R5
  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> (low_len == SW'(SETTLE_CYCLES))) else $error("lock rose early"); // R8
  AST_PEND_NOLOCK: assert property (@(posedge clk) disable iff (rst)
    (pend && !lock) |=> !lock) else $error("lock rose with commit pending"); // R10
endmodule

// File: rtl/clkdiv_prog.sv
module clkdiv_prog
  import clkdiv_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic              clk_ref,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              clk_div_o,
  output logic              lock_o
);
  div_set_t shadow;
  logic     pend, commit_wr, take, load;
  logic     phase_hi, act_byp, act_edge;
  logic     half_q;

  clkdiv_cfg_regs u_cfg (
    .clk(clk_ref), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .take(take),
    .shadow(shadow), .pend(pend), .commit_wr(commit_wr)
  );

  clkdiv_phase_gen u_phase (
    .clk(clk_ref), .rst(rst), .pend(pend), .shadow(shadow),
    .take(take), .load(load), .phase_hi(phase_hi),
    .act_byp(act_byp), .act_edge(act_edge)
  );

  clkdiv_lock_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_lock (
    .clk(clk_ref), .rst(rst), .commit_wr(commit_wr), .load(load),
    .pend(pend), .lock(lock_o)
  );

  // Falling-edge copy stretches the high phase by half a reference cycle.
  always_ff @(negedge clk_ref) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= phase_hi & act_edge;
  end

  assign clk_div_o = act_byp ? clk_ref : (phase_hi | half_q);

  AST_HALF_OFF: assert property (@(posedge clk_ref) disable iff (rst)
    !act_edge |-> !half_q) else $error("half-cycle stretch without edge select"); // R4
endmodule

// File: tb/test_clkdiv_prog.sv
module test_clkdiv_prog;
  localparam int S = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        clk_div_o, lock_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  clkdiv_prog #(.SETTLE_CYCLES(S)) i_clkdiv_prog (
    .clk_ref(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .clk_div_o(clk_div_o), .lock_o(lock_o)
  );

  always #5 clk = ~clk;

  // ---------------- reference model (period-position based) ----------------
  int m_lo = 1, m_hi = 1, m_pos = 0, m_sett = 0;
  bit m_byp = 1, m_edge = 0, m_swap = 0, m_pend = 0, m_lock = 1, m_run = 0;
  bit m_p = 0, m_n = 0;
  int sh_lo = 1, sh_hi = 1;
  bit sh_edge = 0, sh_byp = 1;

  function automatic int nz(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lo = 1; m_hi = 1; m_pos = 0; m_sett = 0; m_byp = 1; m_edge = 0;
      m_swap = 0; m_pend = 0; m_lock = 1; m_run = 0; m_p = 0;
      sh_lo = 1; sh_hi = 1; sh_edge = 0; sh_byp = 1;
    end else begin
      bit commit, at_end, take, load, rise;
      commit = cfg_we && !cfg_wdata[14];
      at_end = m_byp || (m_pos == m_lo + m_hi - 1);
      take   = !m_swap && at_end && m_pend;
      load   = m_swap;
      rise   = !commit && m_run && m_sett == 0 && !m_pend && !load;
      if (commit) m_lock = 0;
      else if (rise) begin m_lock = 1; m_run = 0; end
      if (load) begin m_sett = S - 1; m_run = 1; end
      else if (m_run && m_sett != 0) m_sett--;
      if (load) begin
        m_byp = sh_byp; m_edge = sh_edge; m_lo = nz(sh_lo); m_hi = nz(sh_hi);
        m_pos = 0; m_swap = 0;
      end else if (take) m_swap = 1;
      else if (!m_byp) m_pos = (m_pos == m_lo + m_hi - 1) ? 0 : m_pos + 1;
      if (commit) m_pend = 1; else if (take) m_pend = 0;
      if (cfg_we) begin
        sh_lo = cfg_wdata[5:0]; sh_hi = cfg_wdata[11:6];
        sh_edge = cfg_wdata[12]; sh_byp = cfg_wdata[13];
      end
      m_p = !m_byp && !m_swap && (m_pos < m_hi);
    end
  end

  always @(negedge clk) begin
    if (rst) m_n = 0;
    else     m_n = m_p && m_edge;
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic string out_tag();
    if (m_byp)  return "R3";
    if (m_swap) return "R7";
    if (m_edge) return "R4";
    return "R2";
  endfunction

  // compare on every clock, at both edges
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      check(out_tag(), clk_div_o, m_byp ? clk : (m_p | m_n));
      check("R8", lock_o, m_lock);
    end
  end
  always @(negedge clk) begin
    #2;
    if (!rst) check(out_tag(), clk_div_o, m_byp ? clk : (m_p | m_n));
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mk(input int lo, input int hi, input bit e,
                                     input bit b, input bit nu);
    logic [31:0] w;
    w = '0;
    w[5:0] = lo[5:0]; w[11:6] = hi[5:0];
    w[12] = e; w[13] = b; w[14] = nu;
    return w;
  endfunction

  function automatic logic [31:0] enc(input int n, input bit upd);
    return mk((n % 2 == 0) ? n / 2 : n / 2 + 1, n / 2, n % 2, n == 1, !upd);
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(posedge clk); #2;
    if (!w[14]) check("R6", lock_o, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_lock();
    int n = 0;
    do begin @(posedge clk); #3; n++; end while (!lock_o && n < 1000);
    check("R8", lock_o, 1'b1);
    n_chk++;
    if (n <= S) begin
      n_fail++;
      $display("FAIL R8: lock low %0d cycles, expected more than %0d", n, S);
    end
  endtask

  task automatic count_high(input int cycles, input string req, input int exp);
    int h = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #2;
      if (clk_div_o) h++;
    end
    check_int(req, h, exp);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    check("R1", lock_o, 1'b1);
    check("R1", clk_div_o, 1'b1);
    @(negedge clk); #2;
    check("R1", clk_div_o, 1'b0);
    run(5);

    wr(enc(4, 1)); wait_lock();            // R2 even ratio
    count_high(40, "R2", 20);

    wr(enc(5, 1)); wait_lock(); run(50);   // R4 odd ratio, 50% duty

    wr(enc(6, 0));                         // R5 staged only
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #2;
      check("R5", lock_o, 1'b1);
    end
    wr(enc(6, 1)); wait_lock(); run(30);

    wr(mk(0, 0, 0, 0, 0)); wait_lock();    // R9 zero counts act as one
    count_high(20, "R9", 10);

    wr(enc(4, 1) | 32'hFFFF_8000); wait_lock(); // R2 upper bits ignored
    count_high(40, "R2", 20);

    wr(enc(7, 1)); wr(enc(3, 1)); wait_lock(); run(30); // R10 back-to-back

    wr(enc(9, 1)); run(30); wr(enc(2, 1)); wait_lock(); run(20); // R10 during settle

    wr(mk(5, 9, 0, 1, 0)); wait_lock(); run(20); // R3 bypass ignores counts

    wr(enc(126, 1)); wait_lock(); run(300);       // max ratio
    count_high(126, "R2", 63);

    wr(enc(1, 1)); wait_lock(); run(10);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule